// File: doc/BRIEF.md
# Serially Programmed Echo Delay Line

This block is the digital core of an echo and surround processor. A control word arrives over a slow three-wire serial link. Each data bit is taken on a rising serial clock, and the word takes effect on a rising latch line. From that word the block decodes the echo delay setting, the source and routing selectors, an output enable, and two volume settings. The delay setting fixes two things at once: how many system clocks lie between audio samples, and how many samples the circular delay memory holds before it plays them back.

Audio samples enter through a valid/ready port. The block raises `in_ready` for exactly one clock per sample period. It accepts whatever sits on `in_data` during that cycle. If `in_valid` is low in that cycle, it records a silent (zero) sample. There is no back-pressure on the input: the source cannot delay the sample slot, and a slot it misses is lost as silence. The output is a one-cycle `out_valid` strobe and cannot be stalled. Every accepted slot produces exactly one output one clock later.

After reset, and every time a newly latched word carries a different delay code, the delay output is held at zero. The mute lasts until the memory has been filled once at the new length, so stale audio from another setting is never heard.

Top module: `serial_echo_delay`

## Requirements
- R1: `ser_dat` is sampled on each rising edge of `ser_clk`, and the first bit sent lands in bit 0 of the word. A rising edge of `ser_lat` commits the 16 most recent bits. Bits shifted in without a latch leave every decoded output unchanged.
- R2: The delay code is bits [2:0], and bit 0 is its least significant bit. The input select is bits [4:3], the output select is bits [6:5], and the output enable is bit 7. All of these appear unchanged on their outputs.
- R3: Bits [10:8] give the delay volume code v. For v from 0 to 6, `dly_gain_db` = 3 - 3v (signed) and `dly_off` = 0. For v = 7, `dly_off` = 1 and `dly_gain_db` = 0.
- R4: Bits [13:11] give the feedback volume code f. For f from 0 to 6, `fb_gain_db` = -3 - 2f and `fb_off` = 0. For f = 7, `fb_off` = 1 and `fb_gain_db` = 0.
- R5: `in_ready` is high for one cycle in every D clocks. D is 6 for delay codes 0 to 4, 12 for code 5, 18 for code 6 and 24 for code 7.
- R6: The delay in samples is L = floor(T x CLK_KHZ / (10 x D)). T is given in tenths of a millisecond: 92, 154, 211, 300, 480, 960, 1440 and 1920 for codes 0 to 7. Once the line is unmuted, each output equals the sample accepted L slots earlier. A slot with `in_valid` low counts as a zero sample.
- R7: `out_valid` is high exactly in the cycle after each cycle in which `in_ready` is high, and at no other time.
- R8: After reset the delay code is 0, and the first L outputs are zero.
- R9: A committed word whose delay code differs from the current one restarts the sample timing in the clock after the change is visible. `in_ready` stays low in that clock, and the next L outputs are zero.
- R10: A committed word with the same delay code updates the other fields without restarting the timing and without muting.
- R11: Reset clears the configuration word to all zeros: `dly_gain_db` = 3, `fb_gain_db` = -3, and both off flags are 0. During reset `in_ready` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data bit |
| ser_lat | input | 1 | Serial commit strobe |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Sample slot pulse; the input is taken in this cycle |
| in_data | input | DW | Input audio sample |
| out_valid | output | 1 | Delayed sample strobe |
| out_data | output | DW | Delayed audio sample, zero while muted |
| cfg_delay_code | output | 3 | Committed delay code |
| cfg_in_sel | output | 2 | Committed input source select |
| cfg_out_sel | output | 2 | Committed output routing select |
| cfg_out_on | output | 1 | Committed output enable |
| dly_gain_db | output | 6 | Delay volume in dB, signed |
| dly_off | output | 1 | Delay volume fully off |
| fb_gain_db | output | 6 | Feedback volume in dB, signed |
| fb_off | output | 1 | Feedback volume fully off |

## Verification
A behavioural model fed with the same stimulus follows the stream through three input patterns. In the first, every sample slot is filled with a changing value, which exposes any off-by-one in delay length or address wrap. In the second, `in_valid` drops periodically, which separates a slot recorded as silence from a slot that is skipped. In the third, `in_valid` stays low throughout, which shows that no stale data leaks out. The runs cover the short and long divisors and a change of delay code. They also send a word that repeats the current code, which shows the difference between a restart with mute and a plain field update. A word shifted in with no latch must leave every decoded output unchanged.

// File: rtl/echo_pkg.sv
package echo_pkg;

  localparam int NUM_CODES = 8;
  localparam int SER_W     = 16;
  localparam int CFG_W     = 14;
  localparam int GAIN_W    = 6;
  localparam int DIV_MAX   = 24;

  localparam int CODE_LSB  = 0;
  localparam int ISEL_LSB  = 3;
  localparam int OSEL_LSB  = 5;
  localparam int OUTON_BIT = 7;
  localparam int DVOL_LSB  = 8;
  localparam int FVOL_LSB  = 11;

  typedef struct packed {
    logic [2:0]               delay_code;
    logic [1:0]               in_sel;
    logic [1:0]               out_sel;
    logic                     out_on;
    logic signed [GAIN_W-1:0] dly_gain_db;
    logic                     dly_off;
    logic signed [GAIN_W-1:0] fb_gain_db;
    logic                     fb_off;
  } echo_cfg_t;

  function automatic int div_for(int code);
    return (code < 5) ? 6 : (code - 3) * 6;
  endfunction

  function automatic int tenth_ms(int code);
    case (code)
      0:       return 92;
      1:       return 154;
      2:       return 211;
      3:       return 300;
      4:       return 480;
      5:       return 960;
      6:       return 1440;
      default: return 1920;
    endcase
  endfunction

  function automatic int len_for(int code, int khz);
    int n;
    n = tenth_ms(code) * khz / (div_for(code) * 10);
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int max_len(int khz);
    int m;
    m = 1;
    for (int c = 0; c < NUM_CODES; c++)
      if (len_for(c, khz) > m) m = len_for(c, khz);
    return m;
  endfunction

endpackage

// File: rtl/echo_sync.sv
module echo_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/echo_serial_rx.sv
module echo_serial_rx
  import echo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_lat,
  output logic [CFG_W-1:0] word,
  output logic             commit,
  output logic             code_chg
);
  logic clk_s, dat_s, lat_s;
  logic clk_d, lat_d;
  logic bit_take;
  logic [SER_W-1:0] shreg;

  echo_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (.clk(clk), .rst(rst), .d(ser_clk), .q(clk_s));
  echo_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (.clk(clk), .rst(rst), .d(ser_dat), .q(dat_s));
  echo_sync #(.STAGES(SYNC_STAGES)) u_sync_lat (.clk(clk), .rst(rst), .d(ser_lat), .q(lat_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_d <= 1'b0;
      lat_d <= 1'b0;
    end else begin
      clk_d <= clk_s;
      lat_d <= lat_s;
    end
  end

  assign bit_take = clk_s & ~clk_d;
  assign commit   = lat_s & ~lat_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      word     <= '0;
      code_chg <= 1'b0;
    end else begin
      if (bit_take) shreg <= {dat_s, shreg[SER_W-1:1]};
      code_chg <= 1'b0;
      if (commit) begin
        word     <= shreg[CFG_W-1:0];
        code_chg <= shreg[CODE_LSB +: 3] != word[CODE_LSB +: 3];
      end
    end
  end
endmodule

// File: rtl/echo_cfg_decode.sv
module echo_cfg_decode
  import echo_pkg::*;
(
  input  logic [CFG_W-1:0] word,
  output echo_cfg_t        cfg
);
  logic [2:0]        dv, fv;
  logic signed [7:0] dg, fg;

  always_comb begin
    dv = word[DVOL_LSB +: 3];
    fv = word[FVOL_LSB +: 3];
    dg = 8'sd3 - 8'sd3 * $signed({5'b0, dv});
    fg = -8'sd3 - 8'sd2 * $signed({5'b0, fv});

    cfg.delay_code  = word[CODE_LSB +: 3];
    cfg.in_sel      = word[ISEL_LSB +: 2];
    cfg.out_sel     = word[OSEL_LSB +: 2];
    cfg.out_on      = word[OUTON_BIT];
    cfg.dly_off     = &dv;
    cfg.fb_off      = &fv;
    cfg.dly_gain_db = (&dv) ? '0 : dg[GAIN_W-1:0];
    cfg.fb_gain_db  = (&fv) ? '0 : fg[GAIN_W-1:0];
  end
endmodule

// File: rtl/echo_delay_core.sv
module echo_delay_core
  import echo_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CLK_KHZ = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    code,
  input  logic          restart,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          muted
);
  localparam int DEPTH = max_len(CLK_KHZ);
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DIV_MAX);

  logic [AW-1:0] last_addr [NUM_CODES];
  logic [CW-1:0] last_cnt  [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
    assign last_addr[g] = AW'(len_for(g, CLK_KHZ) - 1);
    assign last_cnt[g]  = CW'(div_for(g) - 1);
  end

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] div_cnt;
  logic [AW-1:0] wptr;
  logic          tick, wrap;

  assign tick     = (div_cnt == last_cnt[code]) & ~restart;
  assign wrap     = (wptr == last_addr[code]);
  assign in_ready = tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt   <= '0;
      wptr      <= '0;
      muted     <= 1'b1;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (restart) begin
      div_cnt   <= '0;
      wptr      <= '0;
      muted     <= 1'b1;
      out_valid <= 1'b0;
    end else begin
      out_valid <= tick;
      if (tick) begin
        div_cnt  <= '0;
        out_data <= muted ? '0 : mem[wptr];
        if (wrap) begin
          wptr  <= '0;
          muted <= 1'b0;
        end else begin
          wptr <= wptr + 1'b1;
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && tick) mem[wptr] <= in_valid ? in_data : '0;
  end
endmodule

// File: rtl/serial_echo_delay.sv
module serial_echo_delay
  import echo_pkg::*;
#(
  parameter int DW          = 16,
  parameter int CLK_KHZ     = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ser_clk,
  input  logic                     ser_dat,
  input  logic                     ser_lat,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [DW-1:0]            in_data,
  output logic                     out_valid,
  output logic [DW-1:0]            out_data,
  output logic [2:0]               cfg_delay_code,
  output logic [1:0]               cfg_in_sel,
  output logic [1:0]               cfg_out_sel,
  output logic                     cfg_out_on,
  output logic signed [GAIN_W-1:0] dly_gain_db,
  output logic                     dly_off,
  output logic signed [GAIN_W-1:0] fb_gain_db,
  output logic                     fb_off
);
  logic [CFG_W-1:0] cfg_word;
  logic             lat_commit;
  logic             code_chg;
  logic             core_muted;
  echo_cfg_t        cfg;

  echo_serial_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
    .word(cfg_word), .commit(lat_commit), .code_chg(code_chg)
  );

  echo_cfg_decode u_dec (.word(cfg_word), .cfg(cfg));

  echo_delay_core #(.DW(DW), .CLK_KHZ(CLK_KHZ)) u_core (
    .clk(clk), .rst(rst), .code(cfg.delay_code), .restart(code_chg),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .muted(core_muted)
  );

  assign cfg_delay_code = cfg.delay_code;
  assign cfg_in_sel     = cfg.in_sel;
  assign cfg_out_sel    = cfg.out_sel;
  assign cfg_out_on     = cfg.out_on;
  assign dly_gain_db    = cfg.dly_gain_db;
  assign dly_off        = cfg.dly_off;
  assign fb_gain_db     = cfg.fb_gain_db;
  assign fb_off         = cfg.fb_off;
endmodule

// File: rtl/echo_delay_chk.sv
module echo_delay_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          muted,
  input logic          chg,
  input logic          commit,
  input logic [2:0]    cfg_delay_code
);
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> !in_ready);                                   // R5
  AST_VALID_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> out_valid);                                   // R7
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> !out_valid);                                 // R7
  AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(muted)) |-> (out_data == '0));         // R8
  AST_CHANGE_MUTES: assert property (@(posedge clk) disable iff (rst)
    chg |=> muted);                                            // R9
  AST_CHANGE_NO_SLOT: assert property (@(posedge clk) disable iff (rst)
    chg |-> !in_ready);                                        // R9
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(cfg_delay_code));                      // R1
endmodule

bind serial_echo_delay echo_delay_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .muted(core_muted), .chg(code_chg),
  .commit(lat_commit), .cfg_delay_code(cfg_delay_code)
);

// File: tb/test_serial_echo_delay.sv
module test_serial_echo_delay;
  localparam int DW  = 16;
  localparam int KHZ = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, cfg_out_on, dly_off, fb_off;
  logic [DW-1:0] out_data;
  logic [2:0] cfg_delay_code;
  logic [1:0] cfg_in_sel, cfg_out_sel;
  logic signed [5:0] dly_gain_db, fb_gain_db;

  always #10 clk = ~clk;

  serial_echo_delay #(.DW(DW), .CLK_KHZ(KHZ)) i_serial_echo_delay (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .cfg_delay_code(cfg_delay_code), .cfg_in_sel(cfg_in_sel), .cfg_out_sel(cfg_out_sel),
    .cfg_out_on(cfg_out_on), .dly_gain_db(dly_gain_db), .dly_off(dly_off),
    .fb_gain_db(fb_gain_db), .fb_off(fb_off)
  );

  int n_chk = 0, n_bad = 0;
  string cur_req = "R6,R8";
  int pattern = 0;
  bit done = 0;

  function automatic int div_of(int c);
    if (c <= 4) return 6;
    if (c == 5) return 12;
    if (c == 6) return 18;
    return 24;
  endfunction

  function automatic int len_of(int c);
    int t[8] = '{92, 154, 211, 300, 480, 960, 1440, 1920};
    return t[c] * KHZ / (10 * div_of(c));
  endfunction

  function automatic logic [15:0] mk(int code, int isel, int osel, int on, int dv, int fv);
    logic [15:0] w;
    w = '0;
    w[2:0] = code[2:0]; w[4:3] = isel[1:0]; w[6:5] = osel[1:0];
    w[7] = on[0]; w[10:8] = dv[2:0]; w[13:11] = fv[2:0];
    return w;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] q[$];
  int m_cnt = 0, m_prev = 0, m_k = 0;
  bit exp_valid = 0;
  logic [DW-1:0] exp_data = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_prev = 0; m_k = 0; q.delete(); exp_valid = 0;
    end else begin
      exp_valid = 0;
      if (int'(cfg_delay_code) != m_prev) begin
        m_prev = int'(cfg_delay_code); m_cnt = 0; m_k = 0; q.delete();
      end else if (m_cnt == div_of(m_prev) - 1) begin
        logic [DW-1:0] popped;
        popped = '0;
        q.push_back(in_valid ? in_data : '0);
        if (q.size() > len_of(m_prev)) popped = q.pop_front();
        exp_valid = 1;
        exp_data = (m_k >= len_of(m_prev)) ? popped : '0;
        m_k++;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit exp_rdy;
      exp_rdy = (m_cnt == div_of(m_prev) - 1) && (int'(cfg_delay_code) == m_prev);
      chk(in_ready == exp_rdy, "R5", "in_ready", int'(in_ready), int'(exp_rdy));
      chk(out_valid == exp_valid, "R7", "out_valid", int'(out_valid), int'(exp_valid));
      if (exp_valid)
        chk(out_data == exp_data, cur_req, "out_data", int'(out_data), int'(exp_data));
    end
  end

  // input stream driver
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      in_data  = DW'(cyc * 37 + 11);
      in_valid = (pattern == 0) ? 1'b1 : (pattern == 1) ? ((cyc % 5) != 3) : 1'b0;
    end
  end

  task automatic send(logic [15:0] w, bit latch);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); ser_dat = w[i];
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (3) @(negedge clk); ser_clk = 1'b0;
      repeat (2) @(negedge clk);
    end
    if (latch) begin
      repeat (2) @(negedge clk); ser_lat = 1'b1;
      repeat (3) @(negedge clk); ser_lat = 1'b0;
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic check_cfg(int code, int isel, int osel, int on, int dv, int fv, string tag);
    int eg;
    chk(int'(cfg_delay_code) == code, "R2", {tag, " delay code"}, int'(cfg_delay_code), code);
    chk(int'(cfg_in_sel) == isel, "R2", {tag, " in_sel"}, int'(cfg_in_sel), isel);
    chk(int'(cfg_out_sel) == osel, "R2", {tag, " out_sel"}, int'(cfg_out_sel), osel);
    chk(int'(cfg_out_on) == on, "R2", {tag, " out_on"}, int'(cfg_out_on), on);
    eg = (dv == 7) ? 0 : 3 - 3 * dv;
    chk(int'(dly_gain_db) == eg, "R3", {tag, " dly gain"}, int'(dly_gain_db), eg);
    chk(int'(dly_off) == int'(dv == 7), "R3", {tag, " dly off"}, int'(dly_off), int'(dv == 7));
    eg = (fv == 7) ? 0 : -3 - 2 * fv;
    chk(int'(fb_gain_db) == eg, "R4", {tag, " fb gain"}, int'(fb_gain_db), eg);
    chk(int'(fb_off) == int'(fv == 7), "R4", {tag, " fb off"}, int'(fb_off), int'(fv == 7));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R11: reset state
    check_cfg(0, 0, 0, 0, 0, 0, "R11 reset");
    chk(in_ready == 1'b0, "R11", "in_ready in reset", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;

    // R8, R6: mute after reset, then code 0 delay
    cur_req = "R6,R8";
    repeat ((len_of(0) + 15) * div_of(0)) @(negedge clk);

    // R1, R2, R9: change to code 5 with gaps in the input
    pattern = 1;
    cur_req = "R9";
    send(mk(5, 2, 1, 1, 3, 5), 1'b1);
    check_cfg(5, 2, 1, 1, 3, 5, "R1 word A");
    repeat ((len_of(5) + 20) * div_of(5)) @(negedge clk);

    // R1: shifted word without latch changes nothing
    send(mk(2, 1, 3, 0, 1, 0), 1'b0);
    check_cfg(5, 2, 1, 1, 3, 5, "R1 no latch");

    // R10: same code, other fields change, no restart
    cur_req = "R10";
    send(mk(5, 3, 2, 0, 6, 2), 1'b1);
    check_cfg(5, 3, 2, 0, 6, 2, "R10 word C");
    repeat (300) @(negedge clk);

    // R3, R4, R5, R9: longest divisor, volumes off, silent input first
    pattern = 2;
    cur_req = "R5,R9";
    send(mk(7, 0, 3, 1, 7, 7), 1'b1);
    check_cfg(7, 0, 3, 1, 7, 7, "R3 R4 word D");
    repeat (40 * div_of(7)) @(negedge clk);
    pattern = 0;
    repeat ((len_of(7) + 10) * div_of(7)) @(negedge clk);

    // R6: code 3
    pattern = 1;
    cur_req = "R6";
    send(mk(3, 1, 0, 1, 0, 6), 1'b1);
    check_cfg(3, 1, 0, 1, 0, 6, "R6 word E");
    repeat ((len_of(3) + 20) * div_of(3)) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule